// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block is a small memory-mapped register bank that holds the programming for a set of address-protection regions. Software reaches it through a plain synchronous port made of a byte offset, a write enable, write data and registered read data. A global control register turns protection on and off. A read-only type register reports how many regions are built. For each region the bank stores a base address and an attribute/size word. The decoded fields of every region are driven out continuously to a separate access checker: base, size, access permission, execute-never, memory type, subregion mask and enable.

Software has two ways to pick the region that the base and attribute registers address. It can write a region-number register. It can also set a valid flag inside the base-address write itself, which redirects that write and updates the region number in the same step. If that embedded number names a region that does not exist, the override is dropped and the region-number register decides. Two alias pairs of registers repeat the base and attribute windows, so a setup routine can program several regions with back-to-back writes.

Top module: `prot_cfg_regs`

## Requirements
- R1: After reset, the control bits are all zero, the region-number register is 0 and every region enable is 0. The type register at offset 0x00 reads 0x0000_0800, with the region count in bits 15:8.
- R2: Writes to the type register at 0x00 have no effect. It keeps reading 0x0000_0800.
- R3: The control register at 0x04 stores three bits: bit 0 is the global enable, bit 1 is the fault-handler bypass and bit 2 is the privileged default map. They drive ctl_en_o, ctl_fault_bypass_o and ctl_priv_dflt_o. Bits 31:3 read as zero.
- R4: The region-number register at 0x08 holds bits 7:0. The base register (0x0C) and the attribute register (0x10) address the region given by that number. When the number is 8 or more, both registers read as zero and writes to them are dropped.
- R5: A base write with bit 4 set and bits 3:0 below 8 goes to the region given by bits 3:0. The same write loads that value into the region-number register.
- R6: A base write with bit 4 set and bits 3:0 of 8 or more goes to the region selected by the region-number register, which stays unchanged.
- R7: The base register keeps bits 31:5 of the written value. A read returns those bits, with bit 4 as 0 and bits 3:0 equal to bits 3:0 of the region number.
- R8: The attribute register keeps bits 28, 26:24, 21:16, 15:8 and 5:0, and reads all other bits as zero. Its fields are exported as follows: bit 28 to reg_xn_o, bits 26:24 to reg_ap_o, bits 21:16 to reg_memattr_o, bits 15:8 to reg_srd_o, bits 5:1 to reg_size_o and bit 0 to reg_en_o.
- R9: The exported base of a region is the stored base with bits below max(size+1, 5) cleared. A size field of 31 therefore exports a base of zero.
- R10: Offsets 0x14 and 0x1C act exactly as the base register, including the override. Offsets 0x18 and 0x20 act exactly as the attribute register.
- R11: rdata_o is registered. It carries the value that the offset presented at the previous clock edge held before any write in that same cycle. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register access |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ctl_en_o | output | 1 | Global protection enable |
| ctl_fault_bypass_o | output | 1 | Protection bypass inside fault handlers |
| ctl_priv_dflt_o | output | 1 | Privileged default map enable |
| reg_en_o | output | 8 | Per-region enable |
| reg_base_o | output | 256 | Per-region aligned base, 32 bits per region |
| reg_size_o | output | 40 | Per-region size code, 5 bits per region |
| reg_ap_o | output | 24 | Per-region access permission, 3 bits per region |
| reg_xn_o | output | 8 | Per-region execute-never |
| reg_memattr_o | output | 48 | Per-region type-extension, shareable, cacheable and bufferable bits, 6 bits per region |
| reg_srd_o | output | 64 | Per-region subregion disable mask, 8 bits per region |

## Verification
The hardest case to reach is an out-of-range override. It needs a base write whose valid flag is set and whose region field is 8 to 15, landing while the region-number register already points at a real region. The directed sequence sets that up on purpose: it uses a base value whose low byte happens to carry that pattern, right after selecting region 3. A pseudo-random phase then mixes region-number writes in the 0 to 15 range with base, alias and attribute writes. A behavioural model compares the read data and every exported field on each cycle, covering both valid and stale selections.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam logic [5:0] W_TYPE = 6'd0;
  localparam logic [5:0] W_CTL  = 6'd1;
  localparam logic [5:0] W_RNR  = 6'd2;
  localparam logic [5:0] W_BASE = 6'd3;
  localparam logic [5:0] W_ATTR = 6'd4;
  localparam logic [5:0] W_ALIAS0 = 6'd5;

  localparam logic [31:0] ATTR_KEEP = 32'h173F_FF3F;
  localparam logic [31:0] BASE_KEEP = 32'hFFFF_FFE0;

  typedef enum logic [2:0] {
    K_NONE, K_TYPE, K_CTL, K_RNR, K_BASE, K_ATTR
  } reg_kind_e;

  typedef struct packed {
    logic       xn;
    logic [2:0] ap;
    logic [5:0] memattr;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } region_fields_t;

  // bits kept in the exported base for a given size code
  function automatic logic [31:0] base_keep_mask(input logic [4:0] sz);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      m[i] = (i >= 5) && (i > int'(sz));
    end
    return m;
  endfunction

  function automatic region_fields_t split_attr(input logic [31:0] a);
    region_fields_t f;
    f.xn      = a[28];
    f.ap      = a[26:24];
    f.memattr = a[21:16];
    f.srd     = a[15:8];
    f.size    = a[5:1];
    f.en      = a[0];
    return f;
  endfunction
endpackage

// File: rtl/prot_cfg_decode.sv
module prot_cfg_decode
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_ALIAS   = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [7:0]       addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic [7:0]       rnr_i,
  output reg_kind_e        kind_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             wr_ok_o,
  output logic             ovr_hit_o,
  output logic             rnr_ok_o
);
  localparam int unsigned LAST_ALIAS = int'(W_ALIAS0) + 2 * NUM_ALIAS;

  logic [5:0] word;
  assign word = addr_i[7:2];

  always_comb begin
    kind_o = K_NONE;
    unique case (word)
      W_TYPE:  kind_o = K_TYPE;
      W_CTL:   kind_o = K_CTL;
      W_RNR:   kind_o = K_RNR;
      W_BASE:  kind_o = K_BASE;
      W_ATTR:  kind_o = K_ATTR;
      default: begin
        if (int'(word) >= int'(W_ALIAS0) && int'(word) < LAST_ALIAS)
          kind_o = word[0] ? K_BASE : K_ATTR;
      end
    endcase
  end

  assign rnr_ok_o  = 32'(rnr_i) < NUM_REGIONS;
  assign ovr_hit_o = we_i && (kind_o == K_BASE) && wdata_i[4]
                     && (32'(wdata_i[3:0]) < NUM_REGIONS);
  assign wr_idx_o  = ovr_hit_o ? wdata_i[IDX_W-1:0] : rnr_i[IDX_W-1:0];
  assign wr_ok_o   = ovr_hit_o || rnr_ok_o;
endmodule

// File: rtl/prot_cfg_slot.sv
module prot_cfg_slot
  import prot_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_base_i,
  input  logic           wr_attr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    base_q_o,
  output logic [31:0]    attr_q_o,
  output logic [31:0]    base_eff_o,
  output region_fields_t fields_o
);
  logic [31:0] base_q, attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      attr_q <= '0;
    end else begin
      if (wr_base_i) base_q <= wdata_i & BASE_KEEP;
      if (wr_attr_i) attr_q <= wdata_i & ATTR_KEEP;
    end
  end

  assign fields_o   = split_attr(attr_q);
  assign base_eff_o = base_q & base_keep_mask(fields_o.size);
  assign base_q_o   = base_q;
  assign attr_q_o   = attr_q;
endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_ALIAS   = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                addr_i,
  input  logic                      we_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic                      ctl_en_o,
  output logic                      ctl_fault_bypass_o,
  output logic                      ctl_priv_dflt_o,
  output logic [NUM_REGIONS-1:0]    reg_en_o,
  output logic [NUM_REGIONS*32-1:0] reg_base_o,
  output logic [NUM_REGIONS*5-1:0]  reg_size_o,
  output logic [NUM_REGIONS*3-1:0]  reg_ap_o,
  output logic [NUM_REGIONS-1:0]    reg_xn_o,
  output logic [NUM_REGIONS*6-1:0]  reg_memattr_o,
  output logic [NUM_REGIONS*8-1:0]  reg_srd_o
);
  localparam logic [31:0] TYPE_VAL = {16'h0, 8'(NUM_REGIONS), 8'h0};

  reg_kind_e        kind;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_ok, ovr_hit, rnr_ok;
  logic [7:0]       rnr_q;
  logic [2:0]       ctl_q;
  logic [31:0]      rdata_q, rd_comb;

  logic [31:0]    base_q   [NUM_REGIONS];
  logic [31:0]    attr_q   [NUM_REGIONS];
  logic [31:0]    base_eff [NUM_REGIONS];
  region_fields_t fields   [NUM_REGIONS];

  prot_cfg_decode #(
    .NUM_REGIONS(NUM_REGIONS),
    .NUM_ALIAS  (NUM_ALIAS)
  ) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rnr_i    (rnr_q),
    .kind_o   (kind),
    .wr_idx_o (wr_idx),
    .wr_ok_o  (wr_ok),
    .ovr_hit_o(ovr_hit),
    .rnr_ok_o (rnr_ok)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    logic sel;
    assign sel = we_i && wr_ok && (wr_idx == IDX_W'(g));

    prot_cfg_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_base_i (sel && kind == K_BASE),
      .wr_attr_i (sel && kind == K_ATTR),
      .wdata_i   (wdata_i),
      .base_q_o  (base_q[g]),
      .attr_q_o  (attr_q[g]),
      .base_eff_o(base_eff[g]),
      .fields_o  (fields[g])
    );

    assign reg_en_o[g]             = fields[g].en;
    assign reg_xn_o[g]             = fields[g].xn;
    assign reg_base_o[g*32 +: 32]  = base_eff[g];
    assign reg_size_o[g*5 +: 5]    = fields[g].size;
    assign reg_ap_o[g*3 +: 3]      = fields[g].ap;
    assign reg_memattr_o[g*6 +: 6] = fields[g].memattr;
    assign reg_srd_o[g*8 +: 8]     = fields[g].srd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnr_q <= '0;
      ctl_q <= '0;
    end else if (we_i) begin
      if (kind == K_RNR)  rnr_q <= wdata_i[7:0];
      else if (ovr_hit)   rnr_q <= {4'h0, wdata_i[3:0]};
      if (kind == K_CTL)  ctl_q <= wdata_i[2:0];
    end
  end

  // reads always follow the stored selection, never a pending override
  always_comb begin
    rd_comb = '0;
    unique case (kind)
      K_TYPE: rd_comb = TYPE_VAL;
      K_CTL:  rd_comb = {29'h0, ctl_q};
      K_RNR:  rd_comb = {24'h0, rnr_q};
      K_BASE: if (rnr_ok)
                rd_comb = {base_q[rnr_q[IDX_W-1:0]][31:5], 1'b0, rnr_q[3:0]};
      K_ATTR: if (rnr_ok) rd_comb = attr_q[rnr_q[IDX_W-1:0]];
      default: rd_comb = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_comb;
  end

  assign rdata_o            = rdata_q;
  assign ctl_en_o           = ctl_q[0];
  assign ctl_fault_bypass_o = ctl_q[1];
  assign ctl_priv_dflt_o    = ctl_q[2];
endmodule

// File: rtl/prot_cfg_regs_chk.sv
module prot_cfg_regs_chk
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_ALIAS   = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [7:0]             addr_i,
  input logic                   we_i,
  input logic [31:0]            wdata_i,
  input logic [31:0]            rdata_o,
  input logic [2:0]             ctl_bits,
  input logic [NUM_REGIONS-1:0] reg_en_o,
  input logic [7:0]             rnr_q
);
  localparam int unsigned LAST_WORD = int'(W_ALIAS0) + 2 * NUM_ALIAS - 1;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic base_wr;
  assign base_wr = we_i && (addr_i[7:2] == W_BASE);

  AST_OVR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr && wdata_i[4] && 32'(wdata_i[3:0]) < NUM_REGIONS)
    |=> rnr_q == {4'h0, $past(wdata_i[3:0])}); // R5

  AST_OVR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr && wdata_i[4] && 32'(wdata_i[3:0]) >= NUM_REGIONS)
    |=> $stable(rnr_q)); // R6

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[7:2] == W_CTL) |=> $stable(ctl_bits)); // R3

  AST_TYPE_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(addr_i[7:2]) == W_TYPE)
    |-> rdata_o == {16'h0, 8'(NUM_REGIONS), 8'h0}); // R2

  AST_EN_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> $countones(reg_en_o ^ $past(reg_en_o)) <= 1); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && int'($past(addr_i[7:2])) > LAST_WORD) |-> rdata_o == 32'h0); // R11
endmodule

bind prot_cfg_regs prot_cfg_regs_chk #(
  .NUM_REGIONS(NUM_REGIONS),
  .NUM_ALIAS  (NUM_ALIAS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ctl_bits({ctl_priv_dflt_o, ctl_fault_bypass_o, ctl_en_o}),
  .reg_en_o(reg_en_o),
  .rnr_q   (rnr_q)
);

// File: tb/prot_cfg_regs_bench.sv
`timescale 1ns/1ps
module prot_cfg_regs_bench;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;

  logic [31:0]    rdata;
  logic           c_en, c_byp, c_pd;
  logic [NR-1:0]  en_w, xn_w;
  logic [NR*32-1:0] base_w;
  logic [NR*5-1:0]  size_w;
  logic [NR*3-1:0]  ap_w;
  logic [NR*6-1:0]  ma_w;
  logic [NR*8-1:0]  srd_w;

  always #10 clk = ~clk;

  prot_cfg_regs u_prot_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .ctl_en_o(c_en), .ctl_fault_bypass_o(c_byp),
    .ctl_priv_dflt_o(c_pd), .reg_en_o(en_w), .reg_base_o(base_w),
    .reg_size_o(size_w), .reg_ap_o(ap_w), .reg_xn_o(xn_w),
    .reg_memattr_o(ma_w), .reg_srd_o(srd_w)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [2:0]  m_ctl;
  logic [7:0]  m_rnr;
  logic [31:0] m_base [NR];
  logic [31:0] m_attr [NR];
  logic [31:0] m_rd;

  function automatic logic [31:0] eff_base(input logic [31:0] b, input logic [31:0] a);
    int lb;
    lb = int'(a[5:1]) + 1;
    if (lb < 5) lb = 5;
    if (lb >= 32) return 32'h0;
    return b & ~((32'h1 << lb) - 32'h1);
  endfunction

  function automatic logic [31:0] m_read(input int w);
    if (w == 0) return 32'h0000_0800;
    if (w == 1) return {29'h0, m_ctl};
    if (w == 2) return {24'h0, m_rnr};
    if (w == 3 || w == 5 || w == 7)
      return (m_rnr < 8) ? {m_base[m_rnr[2:0]][31:5], 1'b0, m_rnr[3:0]} : 32'h0;
    if (w == 4 || w == 6 || w == 8)
      return (m_rnr < 8) ? m_attr[m_rnr[2:0]] : 32'h0;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_rnr = '0; m_rd = '0;
      for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_attr[i] = '0; end
    end else begin
      int w;
      int tgt;
      w = int'(addr[7:2]);
      m_rd = m_read(w);
      if (we) begin
        if (w == 1) m_ctl = wdata[2:0];
        else if (w == 2) m_rnr = wdata[7:0];
        else if (w == 3 || w == 5 || w == 7) begin
          tgt = int'(m_rnr);
          if (wdata[4] && wdata[3:0] < 8) begin
            tgt = int'(wdata[3:0]);
            m_rnr = {4'h0, wdata[3:0]};
          end
          if (tgt < 8) m_base[tgt] = wdata & 32'hFFFF_FFE0;
        end else if (w == 4 || w == 6 || w == 8) begin
          if (m_rnr < 8) m_attr[m_rnr[2:0]] = wdata & 32'h173F_FF3F;
        end
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 rdata vs model", rdata, m_rd);
      chk("R3 ctl vs model", {29'h0, c_pd, c_byp, c_en}, {29'h0, m_ctl});
      for (int i = 0; i < NR; i++) begin
        chk("R8 en vs model", {31'h0, en_w[i]}, {31'h0, m_attr[i][0]});
        chk("R8 fields vs model",
            {3'h0, xn_w[i], 1'b0, ap_w[i*3 +: 3], 2'h0, ma_w[i*6 +: 6], srd_w[i*8 +: 8], 2'h0, size_w[i*5 +: 5], 1'b0},
            m_attr[i] & 32'h173F_FF3E);
        chk("R9 base vs model", base_w[i*32 +: 32], eff_base(m_base[i], m_attr[i]));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 type", v, 32'h0000_0800);
    rd(8'h04, v); chk("R1 ctl", v, 32'h0);
    rd(8'h08, v); chk("R1 rnr", v, 32'h0);
    chk("R1 enables", {24'h0, en_w}, 32'h0);

    // R2 type read-only
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 type after write", v, 32'h0000_0800);

    // R3 control
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R3 ctl readback", v, 32'h7);
    chk("R3 ctl pins all", {29'h0, c_pd, c_byp, c_en}, 32'h7);
    wr(8'h04, 32'h5);
    chk("R3 ctl pins 5", {29'h0, c_pd, c_byp, c_en}, 32'h5);

    // R8 attribute fields, R9 size 31, R7 base readback
    wr(8'h08, 32'h3);
    wr(8'h0C, 32'h2000_0000);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R8 attr reserved bits", v, 32'h173F_FF3F);
    chk("R8 region3 xn/ap", {28'h0, xn_w[3], ap_w[9 +: 3]}, 32'hF);
    chk("R8 region3 memattr", {26'h0, ma_w[18 +: 6]}, 32'h3F);
    chk("R8 region3 srd", {24'h0, srd_w[24 +: 8]}, 32'hFF);
    chk("R8 region3 en", {24'h0, en_w}, 32'h08);
    chk("R9 size 31 base", base_w[96 +: 32], 32'h0);
    rd(8'h0C, v); chk("R7 base readback", v, 32'h2000_0003);

    // R6 out-of-range override (low byte 0x78: bit4=1, bits3:0=8)
    wr(8'h10, 32'h0000_001F);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h08, v); chk("R6 rnr unchanged", v, 32'h3);
    rd(8'h0C, v); chk("R6 base to selected region", v, 32'h1234_5663);
    chk("R9 64KB aligned base", base_w[96 +: 32], 32'h1234_0000);
    chk("R8 size field", {27'h0, size_w[15 +: 5]}, 32'd15);

    // R5 valid override
    wr(8'h0C, 32'h4000_0015);
    rd(8'h08, v); chk("R5 rnr updated", v, 32'h5);
    rd(8'h0C, v); chk("R5 base region5", v, 32'h4000_0005);
    chk("R5 region5 export", base_w[160 +: 32], 32'h4000_0000);
    chk("R5 region3 untouched", base_w[96 +: 32], 32'h1234_0000);

    // R4 out-of-range selection
    wr(8'h08, 32'h20);
    rd(8'h0C, v); chk("R4 base reads zero", v, 32'h0);
    rd(8'h10, v); chk("R4 attr reads zero", v, 32'h0);
    wr(8'h10, 32'h0000_0001);
    wr(8'h0C, 32'hABCD_0000);
    chk("R4 enables unchanged", {24'h0, en_w}, 32'h08);
    rd(8'h08, v); chk("R4 rnr holds", v, 32'h20);

    // R10 alias windows
    wr(8'h14, 32'h8000_0016);
    wr(8'h18, 32'h0300_0011);
    rd(8'h08, v); chk("R10 alias override rnr", v, 32'h6);
    rd(8'h10, v); chk("R10 attr via main", v, 32'h0300_0011);
    rd(8'h1C, v); chk("R10 second base alias", v, 32'h8000_0006);
    rd(8'h20, v); chk("R10 second attr alias", v, 32'h0300_0011);
    chk("R10 enables", {24'h0, en_w}, 32'h48);

    // R11 unmapped and same-cycle read/write
    rd(8'h24, v); chk("R11 unmapped", v, 32'h0);
    rd(8'hFC, v); chk("R11 unmapped high", v, 32'h0);
    @(negedge clk); addr = 8'h10; we = 1'b1; wdata = 32'h0;
    @(negedge clk); chk("R11 old value on write", rdata, 32'h0300_0011); we = 1'b0;
    rd(8'h10, v); chk("R11 new value", v, 32'h0);

    // mixed traffic checked by the model
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 600; k++) begin
      logic [5:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = 6'(lfsr[27:24] % 4'd10);
      @(negedge clk);
      addr  = {w, 2'b00};
      we    = lfsr[7] | lfsr[13];
      wdata = (w == 6'd2) ? (lfsr & 32'h0000_000F) : lfsr;
    end
    @(negedge clk); we = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule